// File: doc/BRIEF.md
# Low-Power Entry Sequencer

This block lives in the always-on domain and carries out a software request to move the chip from active operation into one of two low-power states: a retained sleep state or an ultra deep sleep state in which nothing but the always-on logic keeps power. The sequence starts from a one-cycle request pulse. A mode select, sampled with the request, chooses between the two states.

The request is qualified first. It is refused when the system reports itself busy, or when the remaining sleep time is not larger than the programmed threshold. A refused request raises a one-cycle sleep-failure interrupt and changes nothing else. An accepted request then shuts the chip down in a fixed order on a fixed schedule:

1. Peripheral and radio power-off, checked against an acknowledge.
2. Clock stop and retention.
3. Core power-off together with the regulators, the fast oscillators, brown-out detection and flash.
4. The I/O supply swap, and only then the active I/O regulator.

If the acknowledge is missing, the sequence unwinds to active and interrupts. At completion a warm-boot flag tells boot code whether a warm or a cold restart follows. The block stays in the low-power state until reset.

Top module: `lp_entry_seq`

## Requirements
- R1: After reset, every enable output is 1, and every power-off, gating and retention output is 0. `io_sup_stby`, `sleep_fail_irq`, `warm_boot` and `low_pwr` are also 0.
- R2: A request sampled while `sys_busy` is 1, or while `time_left` is less than or equal to `sleep_thresh`, leaves every output unchanged, except that `sleep_fail_irq` is 1 for exactly the cycle after that edge.
- R3: On an accepted request, `periph_pwr_off` and `radio_pwr_off` go to 1 after the request edge. This edge is edge 1; edges are counted from it.
- R4: `pwr_off_ack` is sampled at edge 5. If it is 0 there, all outputs return to their reset values after that edge and `sleep_fail_irq` is 1 for that one cycle.
- R5: From edge 6, `sys_clk_gate` and `io_retain` are 1. `sram_retain` is 1 only when sleep (`deep_sel`=0) was selected, and stays 0 for ultra deep sleep.
- R6: From edge 9, `core_pwr_off` is 1. From the same edge, `dcdc_en`, `sys_reg_en`, `core_reg_en`, `hfxo_en`, `pll_en`, `hfrc_en`, `bod_en` and `flash_en` are 0.
- R7: From edge 12, `io_sup_stby` is 1 (1 selects the standby I/O regulator). From edge 14, `io_act_reg_en` is 0, so the active I/O regulator is never off while it still feeds the I/O.
- R8: From edge 14, `ret_reg_en` is 0 for ultra deep sleep. For sleep it stays 1.
- R9: `low_pwr` becomes 1 after edge 15, so entry takes 15 edges. At the same time `warm_boot` becomes 1 for sleep or 0 for ultra deep sleep. The block then holds that state until reset.
- R10: Requests and changes of `deep_sel` while a sequence runs, or in the low-power state, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle request pulse |
| deep_sel | input | 1 | 1 = ultra deep sleep, 0 = sleep; sampled with the request |
| sys_busy | input | 1 | Fast peripheral, radio, DMA or flash activity |
| time_left | input | TW | Remaining sleep time |
| sleep_thresh | input | TW | Minimum sleep time worth entering |
| pwr_off_ack | input | 1 | Peripheral and radio switches report off |
| periph_pwr_off | output | 1 | Peripheral power switch off |
| radio_pwr_off | output | 1 | Radio core power switch off |
| sys_clk_gate | output | 1 | System clock stopped |
| sram_retain | output | 1 | SRAM in retention |
| io_retain | output | 1 | I/O state latched |
| core_pwr_off | output | 1 | MCU core power off |
| dcdc_en | output | 1 | Switching converter enable |
| sys_reg_en | output | 1 | System regulator enable |
| core_reg_en | output | 1 | Core regulator enable |
| ret_reg_en | output | 1 | Retention regulator enable |
| hfxo_en | output | 1 | Fast crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| hfrc_en | output | 1 | Fast RC oscillator enable |
| bod_en | output | 1 | Brown-out detector enable |
| flash_en | output | 1 | Flash enable |
| io_sup_stby | output | 1 | I/O supply source, 1 = standby regulator |
| io_act_reg_en | output | 1 | Active I/O regulator enable |
| sleep_fail_irq | output | 1 | Sleep-failure interrupt pulse |
| warm_boot | output | 1 | 1 = warm restart expected |
| low_pwr | output | 1 | Entry complete |

## Verification
The bench targets the threshold boundary, where `time_left` equals `sleep_thresh` and must be refused while one step larger must be accepted. A comparator with the wrong sense would start a sequence the timer cannot cover.

It withholds the acknowledge to exercise the abort at edge 5. A design that ignores the acknowledge would stop clocks on powered peripherals, and one that forgets to unwind would leave the chip half off.

It checks every output at every edge for both modes. This catches an order swap such as dropping the active I/O regulator before the supply swap, retention powered in ultra deep sleep, or a warm-boot flag with the wrong polarity.

It fires extra requests with a flipped mode select mid-sequence, which a design that re-samples the mode would turn into a mixed shutdown.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SEQ,
        ST_LOW
    } seq_state_e;

    typedef struct packed {
        logic periph_off;
        logic radio_off;
        logic clk_gate;
        logic io_ret;
        logic sram_ret;
        logic core_off;
        logic dcdc_en;
        logic sysreg_en;
        logic corereg_en;
        logic retreg_en;
        logic hfxo_en;
        logic pll_en;
        logic hfrc_en;
        logic bod_en;
        logic flash_en;
        logic io_stby;
        logic ioreg_en;
    } pwr_ctl_t;

    // Map a step number of the entry schedule to the power controls.
    function automatic pwr_ctl_t step_decode(
        input int unsigned step,
        input logic        deep,
        input int unsigned ret_at,
        input int unsigned core_at,
        input int unsigned iosw_at,
        input int unsigned ioreg_at
    );
        pwr_ctl_t c;
        logic     p_off;
        logic     ret;
        logic     core;
        logic     reg_off;
        p_off   = (step >= 1);
        ret     = (step >= ret_at);
        core    = (step >= core_at);
        reg_off = (step >= ioreg_at);
        c.periph_off = p_off;
        c.radio_off  = p_off;
        c.clk_gate   = ret;
        c.io_ret     = ret;
        c.sram_ret   = ret & ~deep;
        c.core_off   = core;
        c.dcdc_en    = ~core;
        c.sysreg_en  = ~core;
        c.corereg_en = ~core;
        c.retreg_en  = ~(reg_off & deep);
        c.hfxo_en    = ~core;
        c.pll_en     = ~core;
        c.hfrc_en    = ~core;
        c.bod_en     = ~core;
        c.flash_en   = ~core;
        c.io_stby    = (step >= iosw_at);
        c.ioreg_en   = ~reg_off;
        return c;
    endfunction

endpackage

// File: rtl/lp_req_gate.sv
module lp_req_gate #(
    parameter int TW = 16
) (
    input  logic          req,
    input  logic          idle,
    input  logic          busy,
    input  logic [TW-1:0] time_left,
    input  logic [TW-1:0] thresh,
    output logic          accept,
    output logic          reject
);
    logic fit;

    always_comb begin
        fit    = (time_left > thresh) && !busy;
        accept = req && idle && fit;
        reject = req && idle && !fit;
    end
endmodule

// File: rtl/lp_step_decode.sv
module lp_step_decode
    import lp_seq_pkg::*;
#(
    parameter int CW       = 4,
    parameter int RET_AT   = 6,
    parameter int CORE_AT  = 9,
    parameter int IOSW_AT  = 12,
    parameter int IOREG_AT = 14
) (
    input  logic [CW-1:0] step,
    input  logic          deep,
    output pwr_ctl_t      ctl
);
    always_comb begin
        ctl = step_decode(int'(step), deep, RET_AT, CORE_AT, IOSW_AT, IOREG_AT);
    end
endmodule

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl
    import lp_seq_pkg::*;
#(
    parameter int ENTRY_CYCLES = 15,
    parameter int ACK_AT       = 4,
    parameter int CW           = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          reject,
    input  logic          deep_sel,
    input  logic          ack,
    output logic          idle,
    output logic [CW-1:0] step,
    output logic          deep_q,
    output logic          fail_irq,
    output logic          warm,
    output logic          low
);
    localparam logic [CW-1:0] LAST   = CW'(ENTRY_CYCLES);
    localparam logic [CW-1:0] PRE    = CW'(ENTRY_CYCLES - 1);
    localparam logic [CW-1:0] ACK_CK = CW'(ACK_AT);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            step     <= '0;
            deep_q   <= 1'b0;
            fail_irq <= 1'b0;
            warm     <= 1'b0;
        end else begin
            fail_irq <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (accept) begin
                        state  <= ST_SEQ;
                        step   <= CW'(1);
                        deep_q <= deep_sel;
                    end else if (reject) begin
                        fail_irq <= 1'b1;
                    end
                end
                ST_SEQ: begin
                    if (step == ACK_CK && !ack) begin
                        state    <= ST_RUN;
                        step     <= '0;
                        fail_irq <= 1'b1;
                    end else if (step == PRE) begin
                        state <= ST_LOW;
                        step  <= LAST;
                        warm  <= ~deep_q;
                    end else begin
                        step <= step + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign idle = (state == ST_RUN);
    assign low  = (state == ST_LOW);

    // R10
    seq_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |=> $stable(deep_q));
    // R2
    reject_irq_chk: assert property (@(posedge clk) disable iff (rst)
        reject |=> (fail_irq && state == ST_RUN && step == '0));
    // R4
    ack_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEQ && step == ACK_CK && !ack) |=> (fail_irq && state == ST_RUN));
    // R9
    low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW) |=> (state == ST_LOW && $stable(warm)));
endmodule

// File: rtl/lp_entry_seq.sv
module lp_entry_seq
    import lp_seq_pkg::*;
#(
    parameter int TW           = 16,
    parameter int ENTRY_CYCLES = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_req,
    input  logic          deep_sel,
    input  logic          sys_busy,
    input  logic [TW-1:0] time_left,
    input  logic [TW-1:0] sleep_thresh,
    input  logic          pwr_off_ack,
    output logic          periph_pwr_off,
    output logic          radio_pwr_off,
    output logic          sys_clk_gate,
    output logic          sram_retain,
    output logic          io_retain,
    output logic          core_pwr_off,
    output logic          dcdc_en,
    output logic          sys_reg_en,
    output logic          core_reg_en,
    output logic          ret_reg_en,
    output logic          hfxo_en,
    output logic          pll_en,
    output logic          hfrc_en,
    output logic          bod_en,
    output logic          flash_en,
    output logic          io_sup_stby,
    output logic          io_act_reg_en,
    output logic          sleep_fail_irq,
    output logic          warm_boot,
    output logic          low_pwr
);
    localparam int CW       = $clog2(ENTRY_CYCLES + 1);
    localparam int STEP     = ENTRY_CYCLES / 5;
    localparam int ACK_AT   = STEP + 1;
    localparam int RET_AT   = 2 * STEP;
    localparam int CORE_AT  = 3 * STEP;
    localparam int IOSW_AT  = 4 * STEP;
    localparam int IOREG_AT = 4 * STEP + 2;

    logic          accept;
    logic          reject;
    logic          idle;
    logic [CW-1:0] step;
    logic          deep_q;
    pwr_ctl_t      ctl;

    lp_req_gate #(.TW(TW)) u_gate (
        .req       (sleep_req),
        .idle      (idle),
        .busy      (sys_busy),
        .time_left (time_left),
        .thresh    (sleep_thresh),
        .accept    (accept),
        .reject    (reject)
    );

    lp_seq_ctrl #(.ENTRY_CYCLES(ENTRY_CYCLES), .ACK_AT(ACK_AT), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .reject   (reject),
        .deep_sel (deep_sel),
        .ack      (pwr_off_ack),
        .idle     (idle),
        .step     (step),
        .deep_q   (deep_q),
        .fail_irq (sleep_fail_irq),
        .warm     (warm_boot),
        .low      (low_pwr)
    );

    lp_step_decode #(
        .CW(CW), .RET_AT(RET_AT), .CORE_AT(CORE_AT),
        .IOSW_AT(IOSW_AT), .IOREG_AT(IOREG_AT)
    ) u_dec (
        .step (step),
        .deep (deep_q),
        .ctl  (ctl)
    );

    assign periph_pwr_off = ctl.periph_off;
    assign radio_pwr_off  = ctl.radio_off;
    assign sys_clk_gate   = ctl.clk_gate;
    assign io_retain      = ctl.io_ret;
    assign sram_retain    = ctl.sram_ret;
    assign core_pwr_off   = ctl.core_off;
    assign dcdc_en        = ctl.dcdc_en;
    assign sys_reg_en     = ctl.sysreg_en;
    assign core_reg_en    = ctl.corereg_en;
    assign ret_reg_en     = ctl.retreg_en;
    assign hfxo_en        = ctl.hfxo_en;
    assign pll_en         = ctl.pll_en;
    assign hfrc_en        = ctl.hfrc_en;
    assign bod_en         = ctl.bod_en;
    assign flash_en       = ctl.flash_en;
    assign io_sup_stby    = ctl.io_stby;
    assign io_act_reg_en  = ctl.ioreg_en;

    // R7
    io_order_chk: assert property (@(posedge clk) disable iff (rst)
        !io_act_reg_en |-> io_sup_stby);
    // R6
    core_order_chk: assert property (@(posedge clk) disable iff (rst)
        core_pwr_off |-> (sys_clk_gate && io_retain && periph_pwr_off));
    // R5
    deep_noret_chk: assert property (@(posedge clk) disable iff (rst)
        (deep_q && !idle) |-> !sram_retain);
    // R9
    low_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(low_pwr) |-> (io_sup_stby && !io_act_reg_en && core_pwr_off));
endmodule

// File: tb/sim_lp_entry_seq.sv
`timescale 1ns/1ps
module sim_lp_entry_seq;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_req = 1'b0;
    logic          deep_sel = 1'b0;
    logic          sys_busy = 1'b0;
    logic [TW-1:0] time_left = '0;
    logic [TW-1:0] sleep_thresh = '0;
    logic          pwr_off_ack = 1'b1;
    logic periph_pwr_off, radio_pwr_off, sys_clk_gate, sram_retain, io_retain;
    logic core_pwr_off, dcdc_en, sys_reg_en, core_reg_en, ret_reg_en;
    logic hfxo_en, pll_en, hfrc_en, bod_en, flash_en, io_sup_stby, io_act_reg_en;
    logic sleep_fail_irq, warm_boot, low_pwr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    lp_entry_seq #(.TW(TW), .ENTRY_CYCLES(15)) u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .deep_sel(deep_sel),
        .sys_busy(sys_busy), .time_left(time_left), .sleep_thresh(sleep_thresh),
        .pwr_off_ack(pwr_off_ack), .periph_pwr_off(periph_pwr_off),
        .radio_pwr_off(radio_pwr_off), .sys_clk_gate(sys_clk_gate),
        .sram_retain(sram_retain), .io_retain(io_retain), .core_pwr_off(core_pwr_off),
        .dcdc_en(dcdc_en), .sys_reg_en(sys_reg_en), .core_reg_en(core_reg_en),
        .ret_reg_en(ret_reg_en), .hfxo_en(hfxo_en), .pll_en(pll_en), .hfrc_en(hfrc_en),
        .bod_en(bod_en), .flash_en(flash_en), .io_sup_stby(io_sup_stby),
        .io_act_reg_en(io_act_reg_en), .sleep_fail_irq(sleep_fail_irq),
        .warm_boot(warm_boot), .low_pwr(low_pwr)
    );

    // Expected outputs from the schedule: step s (0 = active), mode, irq, warm, low.
    function automatic logic [19:0] exp_vec(int s, bit deep, bit irq, bit warm, bit low);
        bit po, rt, co, sw, ro;
        po = (s >= 1); rt = (s >= 6); co = (s >= 9); sw = (s >= 12); ro = (s >= 14);
        return {po, po, rt, rt, rt & !deep, co, !co, !co, !co, !(ro & deep),
                !co, !co, !co, !co, !co, sw, !ro, irq, warm, low};
    endfunction

    function automatic string bit_tag(int b);
        if (b >= 18) return "R3";
        if (b >= 15) return "R5";
        if (b == 10) return "R8";
        if (b >= 5)  return "R6";
        if (b >= 3)  return "R7";
        if (b == 2)  return "R2";
        return "R9";
    endfunction

    function automatic logic [19:0] act_vec();
        return {periph_pwr_off, radio_pwr_off, sys_clk_gate, io_retain, sram_retain,
                core_pwr_off, dcdc_en, sys_reg_en, core_reg_en, ret_reg_en,
                hfxo_en, pll_en, hfrc_en, bod_en, flash_en, io_sup_stby,
                io_act_reg_en, sleep_fail_irq, warm_boot, low_pwr};
    endfunction

    task automatic check(string ctx, logic [19:0] exp);
        logic [19:0] act;
        act = act_vec();
        checks++;
        if (act !== exp) begin
            fails++;
            for (int b = 19; b >= 0; b--) begin
                if (act[b] !== exp[b]) begin
                    $display("FAIL %s %s bit%0d act=%b exp=%b (vec act=%h exp=%h)",
                             bit_tag(b), ctx, b, act[b], exp[b], act, exp);
                    break;
                end
            end
        end
    endtask

    // One trial: reset, one request, then an output check after each of 16 edges.
    task automatic trial(bit deep, bit busy, logic [TW-1:0] tl, logic [TW-1:0] th,
                         bit ack_ok, bit extra, string ctx);
        bit acc;
        acc = !busy && (tl > th);
        @(negedge clk); rst = 1'b1; sleep_req = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check({ctx, " R1 reset"}, exp_vec(0, 0, 0, 0, 0));
        deep_sel = deep; sys_busy = busy; time_left = tl; sleep_thresh = th;
        pwr_off_ack = ack_ok; sleep_req = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            logic [19:0] e;
            @(negedge clk);
            sleep_req = 1'b0;
            if (!acc)
                e = exp_vec(0, deep, k == 1, 0, 0);
            else if (!ack_ok)
                e = (k <= 4) ? exp_vec(k, deep, 0, 0, 0) : exp_vec(0, deep, k == 5, 0, 0);
            else
                e = exp_vec(k > 15 ? 15 : k, deep, 0, (k >= 15) && !deep, k >= 15);
            check($sformatf("%s k=%0d", ctx, k), e);
            // R10: extra request with flipped mode mid-sequence and in low power
            if (extra && acc && ack_ok && (k == 3 || k == 15)) begin
                sleep_req = 1'b1;
                deep_sel  = !deep;
                sys_busy  = 1'b0;
            end
        end
        sleep_req = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        // directed corners
        trial(0, 0, 16'd100, 16'd99,  1, 0, "R9 sleep");
        trial(1, 0, 16'd100, 16'd99,  1, 0, "R8 deep");
        trial(0, 0, 16'd50,  16'd50,  1, 0, "R2 equal");
        trial(0, 0, 16'd51,  16'd50,  1, 0, "R2 above");
        trial(1, 1, 16'hFFFF, 16'd0,  1, 0, "R2 busy");
        trial(0, 0, 16'd900, 16'd10,  0, 0, "R4 noack");
        trial(1, 0, 16'd900, 16'd10,  0, 0, "R4 noack deep");
        trial(0, 0, 16'd900, 16'd10,  1, 1, "R10 sleep");
        trial(1, 0, 16'd900, 16'd10,  1, 1, "R10 deep");
        // random mix
        for (int i = 0; i < 40; i++) begin
            bit d, b, a, x;
            logic [TW-1:0] tl, th;
            d  = $urandom_range(1, 0);
            b  = ($urandom_range(3, 0) == 0);
            a  = ($urandom_range(4, 0) != 0);
            x  = $urandom_range(1, 0);
            th = TW'($urandom_range(1000, 0));
            tl = TW'($urandom_range(1200, 0));
            trial(d, b, tl, th, a, x, $sformatf("rand%0d", i));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule